// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Slave with Clock-Domain Handoff

This block lets an 8-bit microcontroller reach FPGA logic over its external memory bus. On that bus one set of eight lines carries the low address byte first and the data after it. The bus strobes are not tied to the FPGA clock in any way. The low address byte is held in a transparent latch that the address-latch strobe opens. Write data is held in a second latch that is open only during a valid write cycle. Neither capture depends on the internal clock.

The write strobe also passes through a two-stage synchronizer into the internal clock domain. Its rising edge there acts as the "new data" event: the captured byte is committed to one of eight memory-mapped registers, and a one-cycle pulse carries the address and data to the rest of the design. When the controller reads, the block drives a byte onto the shared lines. That byte is a holding copy of the addressed register, taken while no read is in progress. The block also decodes four chip-select windows, and it turns both strobes held low together into a reset command.

Top module: `mcu_bus_bridge`

## Requirements
- R1: After reset `wr_pulse` is low and all eight registers read back as 0x00.
- R2: `addr_o` equals the upper address lines concatenated above the low byte. The low byte follows `bus_ad` while `ale` is high and holds once `ale` is low, even if `bus_ad` changes.
- R3: The block drives `bus_ad` only while `ale` is low, `rd_n` is low and `wr_n` is high. At all other times it leaves the lines undriven.
- R4: `chip_sel[i]` is high exactly when the upper address bits (`addr_o[ADDR_W-1:8]`) equal `CS_FIRST_PAGE+i`, for i = 0..3. At any other page no chip select is high. The defaults put the windows at 0x400 to 0x7FF.
- R5: `bus_reset` is high exactly while `rd_n` and `wr_n` are both low.
- R6: A valid write ends when `wr_n` rises while `rd_n` is high. On the third internal clock edge after that rise, `wr_pulse` is high for one cycle, with `wr_addr` and `wr_data` carrying the latched address and byte.
- R7: Registers 0 to 7 live at page `REG_PAGE`, offsets 0x00 to 0x07 (0x100 to 0x107 by default). A write there is returned by a later read. A read of any other address returns 0x00, and a write there changes no register.
- R8: When `wr_n` and `rd_n` rise together after a reset command, no `wr_pulse` is produced and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, unrelated to the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad | inout | 8 | Shared address/data lines |
| bus_hi_addr | input | HI_ADDR_W | Dedicated upper address lines |
| ale | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_o | output | HI_ADDR_W+8 | Full latched address |
| chip_sel | output | 4 | One-hot window selects |
| bus_reset | output | 1 | Reset command (both strobes low) |
| wr_pulse | output | 1 | One-cycle committed-write pulse |
| wr_addr | output | HI_ADDR_W+8 | Address of the committed write |
| wr_data | output | 8 | Byte of the committed write |

## Verification
The bench uses the defaults: HI_ADDR_W=4, CS_FIRST_PAGE=4 and REG_PAGE=1. A 12-bit address then reaches an unmapped page (0), the register page and its unmapped tail (0x108), and every chip-select page (4 to 7). With these values one run covers all four chip-select windows, the "no select" case and both kinds of unmapped read. The strobe edges are placed a fixed 2 ns after the internal clock edge, so the three-edge commit latency of R6 can be checked on an exact cycle.

// File: rtl/mcu_bus_pkg.sv
// Shared constants and types for the multiplexed-bus slave.
package mcu_bus_pkg;
    localparam int unsigned AD_W      = 8;
    localparam int unsigned NUM_CS    = 4;
    localparam int unsigned NUM_REGS  = 8;
    localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);
    typedef logic [AD_W-1:0] bus_byte_t;
endpackage

// File: rtl/mcu_bus_sync.sv
// Two-flop synchronizer for W independent asynchronous levels.
// Assumes each bit is a slow level; no multi-bit coherence is implied.
module mcu_bus_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages; reset to the idle level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mcu_bus_capture.sv
// Strobe-timed capture: address and write-data latches plus cycle decode.
// Assumes the bus holds address and data stable around its strobe edges;
// nothing here uses the internal clock.
module mcu_bus_capture
    import mcu_bus_pkg::*;
#(
    parameter int unsigned HI_W = 4
) (
    input  bus_byte_t            bus_in,
    input  logic [HI_W-1:0]      hi_addr,
    input  logic                 ale,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output logic [HI_W+AD_W-1:0] full_addr,
    output bus_byte_t            wdat,
    output logic                 rd_cycle,
    output logic                 both_low
);
    bus_byte_t lo_addr;
    logic      wr_cycle;

    // Cycle type from the strobe pair.
    always_comb begin
        rd_cycle = !rd_n && wr_n;
        wr_cycle = rd_n && !wr_n;
        both_low = !rd_n && !wr_n;
    end

    // Low address byte is transparent while the latch strobe is high.
    always_latch begin
        if (ale) lo_addr <= bus_in;
    end

    // Write data is transparent during a write data phase, held after it.
    always_latch begin
        if (wr_cycle && !ale) wdat <= bus_in;
    end

    assign full_addr = {hi_addr, lo_addr};
endmodule

// File: rtl/mcu_bus_decode.sv
// Chip-select decoder: one output per fixed 256-byte page window.
// Assumes CS_FIRST_PAGE+NUM_CS-1 fits in the page field.
module mcu_bus_decode
    import mcu_bus_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned CS_FIRST_PAGE = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CS-1:0]  cs
);
    localparam int unsigned PAGE_W = ADDR_W - AD_W;

    logic [PAGE_W-1:0] page;
    assign page = addr[ADDR_W-1:AD_W];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(CS_FIRST_PAGE + i);
        // Window match for select i.
        assign cs[i] = (page == MY_PAGE);
    end
endmodule

// File: rtl/mcu_bus_regfile.sv
// Internal-domain side: write-edge detect, register file, read holding copy.
// Assumes synchronized strobes; the latched address and data are stable
// for at least three internal clocks after the write strobe rises.
module mcu_bus_regfile
    import mcu_bus_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REG_PAGE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n_s,
    input  logic              rd_n_s,
    input  logic              ale_s,
    input  logic [ADDR_W-1:0] addr,
    input  bus_byte_t         wdat,
    output bus_byte_t         rd_data,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output bus_byte_t         wr_data
);
    localparam int unsigned PAGE_W = ADDR_W - AD_W;
    localparam logic [PAGE_W-1:0] MAP_PAGE = PAGE_W'(REG_PAGE);

    bus_byte_t             regs [NUM_REGS];
    logic                  wr_prev, rd_prev, ale_prev;
    logic                  mapped, commit;
    logic [REG_IDX_W-1:0]  idx;

    // Address map check and register index.
    always_comb begin
        mapped = (addr[ADDR_W-1:AD_W] == MAP_PAGE)
              && (addr[AD_W-1:REG_IDX_W] == '0);
        idx    = addr[REG_IDX_W-1:0];
    end

    // Write end: strobe was low and is now high, in a clean write cycle.
    assign commit = !wr_prev && wr_n_s && rd_prev && !ale_prev;

    // Previous synchronized strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev  <= 1'b1;
            rd_prev  <= 1'b1;
            ale_prev <= 1'b0;
        end else begin
            wr_prev  <= wr_n_s;
            rd_prev  <= rd_n_s;
            ale_prev <= ale_s;
        end
    end

    // Commit pulse with the address and data it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_pulse <= commit;
            if (commit) begin
                wr_addr <= addr;
                wr_data <= wdat;
            end
        end
    end

    // Register file update on a committed write to a mapped address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
        end else if (commit && mapped) begin
            regs[idx] <= wdat;
        end
    end

    // Read holding copy, refreshed only while no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_n_s) begin
            rd_data <= mapped ? regs[idx] : '0;
        end
    end
endmodule

// File: rtl/mcu_bus_bridge.sv
// Top: slave on a multiplexed 8-bit bus whose strobes are asynchronous to
// clk. Captures with strobe-timed latches, hands writes over through
// synchronized strobes, and drives read data back onto the shared lines.
module mcu_bus_bridge
    import mcu_bus_pkg::*;
#(
    parameter int unsigned HI_ADDR_W     = 4,
    parameter int unsigned CS_FIRST_PAGE = 4,
    parameter int unsigned REG_PAGE      = 1,
    localparam int unsigned ADDR_W       = HI_ADDR_W + 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    inout  wire  [7:0]           bus_ad,
    input  logic [HI_ADDR_W-1:0] bus_hi_addr,
    input  logic                 ale,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [3:0]           chip_sel,
    output logic                 bus_reset,
    output logic                 wr_pulse,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [7:0]           wr_data
);
    bus_byte_t  wdat, rd_data;
    logic       rd_cycle, bus_oe;
    logic [2:0] strobe_s;

    mcu_bus_capture #(.HI_W(HI_ADDR_W)) u_capture (
        .bus_in    (bus_ad),
        .hi_addr   (bus_hi_addr),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .full_addr (addr_o),
        .wdat      (wdat),
        .rd_cycle  (rd_cycle),
        .both_low  (bus_reset)
    );

    mcu_bus_decode #(.ADDR_W(ADDR_W), .CS_FIRST_PAGE(CS_FIRST_PAGE)) u_decode (
        .addr (addr_o),
        .cs   (chip_sel)
    );

    mcu_bus_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wr_n, rd_n, ale}),
        .q     (strobe_s)
    );

    mcu_bus_regfile #(.ADDR_W(ADDR_W), .REG_PAGE(REG_PAGE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n_s   (strobe_s[2]),
        .rd_n_s   (strobe_s[1]),
        .ale_s    (strobe_s[0]),
        .addr     (addr_o),
        .wdat     (wdat),
        .rd_data  (rd_data),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // Output enable: read data phase only.
    assign bus_oe = !ale && rd_cycle;
    assign bus_ad = bus_oe ? rd_data : 8'hzz;
endmodule

// File: rtl/mcu_bus_bridge_chk.sv
// Property checker for mcu_bus_bridge, attached by bind.
module mcu_bus_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] chip_sel,
    input logic       wr_pulse,
    input logic       bus_reset,
    input logic       bus_oe
);
    // R4: at most one window selected.
    p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel));

    // R6: commit pulse lasts a single cycle.
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R3, R5: no drive while a reset command is on the strobes.
    p_no_drive_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !bus_oe);

    // R1: no commit pulse in the first cycle out of reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !wr_pulse);
endmodule

bind mcu_bus_bridge mcu_bus_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .wr_pulse  (wr_pulse),
    .bus_reset (bus_reset),
    .bus_oe    (bus_oe)
);

// File: tb/mcu_bus_bridge_bench.sv
// Bench: behavioural bus master and register model, compared every clock.
module mcu_bus_bridge_bench;
    localparam int HI = 4;
    localparam int AW = HI + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HI-1:0] bus_hi = '0;
    logic          ale = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]    host_ad = 8'h00;
    logic          host_oe = 1'b1;
    wire  [7:0]    bus_ad;
    logic [AW-1:0] addr_o, wr_addr;
    logic [3:0]    chip_sel;
    logic          bus_reset, wr_pulse;
    logic [7:0]    wr_data;

    int tests = 0, fails = 0;
    bit mon_on = 0, done = 0;
    int m_addr = 0;
    int ref_regs [8];

    assign bus_ad = host_oe ? host_ad : 8'hzz;
    always #10 clk = ~clk;

    mcu_bus_bridge u_mcu_bus_bridge (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_hi_addr(bus_hi),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_o(addr_o),
        .chip_sel(chip_sel), .bus_reset(bus_reset), .wr_pulse(wr_pulse),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_cs(input int a);
        int pg = a / 256;
        return (pg >= 4 && pg <= 7) ? (1 << (pg - 4)) : 0;
    endfunction

    function automatic bit is_reg(input int a);
        return (a >= 'h100) && (a <= 'h107);
    endfunction

    // Per-clock comparison of the decode outputs against the model.
    always @(negedge clk) begin
        if (mon_on) begin
            chk(addr_o == AW'(m_addr), "R2 addr", int'(addr_o), m_addr);
            chk(chip_sel == 4'(exp_cs(m_addr)), "R4 chip_sel", int'(chip_sel), exp_cs(m_addr));
            chk(bus_reset == (!rd_n && !wr_n), "R5 bus_reset", int'(bus_reset), int'(!rd_n && !wr_n));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic addr_phase(input int a);
        cycles(1);
        host_oe = 1; ale = 1; bus_hi = HI'(a >> 8); host_ad = 8'(a); m_addr = a;
        cycles(1);
        ale = 0;
        cycles(1);
        host_ad = 8'hEE;  // R2: must not disturb the held low byte
    endtask

    task automatic bus_write(input int a, input int d);
        addr_phase(a);
        host_ad = 8'(d); wr_n = 0;
        cycles(3);
        wr_n = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(wr_pulse == 0, "R6 pulse early", int'(wr_pulse), 0);
        end
        @(negedge clk);
        chk(wr_pulse == 1, "R6 pulse", int'(wr_pulse), 1);
        chk(wr_addr == AW'(a), "R6 wr_addr", int'(wr_addr), a);
        chk(wr_data == 8'(d), "R6 wr_data", int'(wr_data), d);
        @(negedge clk);
        chk(wr_pulse == 0, "R6 pulse width", int'(wr_pulse), 0);
        if (is_reg(a)) ref_regs[a - 'h100] = d;
        cycles(1);
        host_ad = 8'h00;
    endtask

    task automatic bus_read(input int a, input string req);
        int e = is_reg(a) ? ref_regs[a - 'h100] : 0;
        addr_phase(a);
        host_oe = 0;
        cycles(4);
        rd_n = 0;
        @(negedge clk);
        chk(bus_ad == 8'(e), req, int'(bus_ad), e);
        cycles(1);
        rd_n = 1;
        host_oe = 1; host_ad = 8'h00;  // R3: block must be off the lines
        @(negedge clk);
        chk(bus_ad == 8'h00, "R3 released", int'(bus_ad), 0);
        cycles(1);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) ref_regs[k] = 0;
        cycles(4);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);
        chk(wr_pulse == 0, "R1 pulse idle", int'(wr_pulse), 0);
        for (int k = 0; k < 8; k++) bus_read('h100 + k, "R1 reset value");

        // R6, R7: writes to every register, then readback
        for (int k = 0; k < 8; k++) bus_write('h100 + k, 'h11 * (k + 1) ^ 'h5A);
        for (int k = 0; k < 8; k++) bus_read('h100 + k, "R7 readback");

        // R7: unmapped reads and a write into a chip-select window
        bus_read('h000, "R7 unmapped page0");
        bus_read('h108, "R7 unmapped tail");
        bus_write('h5A3, 'h77);
        bus_read('h5A3, "R7 unmapped cs page");
        bus_read('h100, "R7 unchanged");

        // R4: every window and a page past them
        addr_phase('h400); addr_phase('h6FF); addr_phase('h7C0); addr_phase('h800);

        // R5, R8: reset command on a mapped address
        bus_write('h103, 'hA5);
        addr_phase('h103);
        host_ad = 8'h00;
        cycles(4);
        rd_n = 0; wr_n = 0;
        @(negedge clk);
        chk(bus_reset == 1, "R5 reset cmd", int'(bus_reset), 1);
        chk(bus_ad == 8'h00, "R3 no drive in reset cmd", int'(bus_ad), 0);
        cycles(2);
        rd_n = 1; wr_n = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(wr_pulse == 0, "R8 no commit", int'(wr_pulse), 0);
        end
        bus_read('h103, "R8 register kept");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule